// File: doc/BRIEF.md
# Programmable Duty-Cycle Clock Prescaler

This block derives a slow converter clock from a fast system clock. Software sets the length of the high phase and the length of the low phase with two separate fields, so the output period, its duty cycle and odd division ratios are all programmable. One down counter times both phases: it loads the high-phase length when the output rises, counts to zero, then loads the low-phase length and counts to zero again before the next rise.

Downstream logic that stays in the system clock domain uses a single-cycle enable pulse that marks each rising edge of the converter clock. Because a change of rate in the middle of a conversion would spoil that conversion, field writes are accepted only while the conversion queues report idle. A write attempted at any other time is dropped and latches an error flag. Accepted values are held in shadow registers and applied at the next rising edge of the output, so a phase is never cut short.

Top module: `clk_prescaler`

## Requirements
- R1: While `rst_n` is low, `qclk`, `qclk_en` and `wr_err` are 0 and both fields read as 0. In the first cycle after reset is released, `qclk` rises and `qclk_en` is 1, and with the reset fields the output divides by 2.
- R2: Each high phase of `qclk` lasts exactly `hi_time + 1` system clock cycles, where `hi_time` is the 5-bit unsigned field (1 to 32 cycles).
- R3: Each low phase of `qclk` lasts exactly `lo_time + 1` system clock cycles, where `lo_time` is the 3-bit unsigned field (1 to 8 cycles), so the period runs from 2 to 40 cycles.
- R4: `qclk_en` is 1 for exactly one cycle per period: the first cycle in which `qclk` is high, and in no other cycle.
- R5: A write (`wr_en` = 1) while `idle` = 0 changes neither field and sets `wr_err`, which then stays 1 until reset.
- R6: A write while `idle` = 1 loads both fields; the new values govern the period that starts at the next rise of `qclk` after the write. A write in the last low cycle before a rise leaves that rise's period on the old values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for both timing fields |
| wr_hi | input | 5 | High-phase length minus one |
| wr_lo | input | 3 | Low-phase length minus one |
| idle | input | 1 | 1 when both conversion queues are disabled |
| qclk | output | 1 | Converter clock level |
| qclk_en | output | 1 | One-cycle pulse in the first high cycle of `qclk` |
| wr_err | output | 1 | Sticky flag: a write was refused |

## Verification
The collision of interest is a field write landing on the same edge as the high-phase reload. The bench counts cycles from a known rising edge to place a write exactly in the last low cycle, then measures the next two periods: the first must keep the old phase lengths and only the second may show the new ones. All 256 field combinations are also swept, each high and low phase length compared with the arithmetic value.

// File: rtl/clk_prescaler.sv
module clk_prescaler #(
  parameter int HW = 5,
  parameter int LW = 3,
  parameter logic [HW-1:0] HI_RST = '0,
  parameter logic [LW-1:0] LO_RST = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [HW-1:0] wr_hi,
  input  logic [LW-1:0] wr_lo,
  input  logic          idle,
  output logic          qclk,
  output logic          qclk_en,
  output logic          wr_err
);

  localparam int CW = (HW > LW) ? HW : LW;

  logic [HW-1:0] hi_sh;
  logic [LW-1:0] lo_sh;
  logic [LW-1:0] lo_act;
  logic [CW-1:0] cnt;
  logic          zero;

  assign zero = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_sh  <= HI_RST;
      lo_sh  <= LO_RST;
      wr_err <= 1'b0;
    end else if (wr_en) begin
      if (idle) begin
        hi_sh <= wr_hi;
        lo_sh <= wr_lo;
      end else begin
        wr_err <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      qclk    <= 1'b0;
      qclk_en <= 1'b0;
      lo_act  <= LO_RST;
    end else begin
      qclk_en <= 1'b0;
      if (!zero) begin
        cnt <= cnt - 1'b1;
      end else if (qclk) begin
        qclk <= 1'b0;
        cnt  <= CW'(lo_act);
      end else begin
        qclk    <= 1'b1;
        qclk_en <= 1'b1;
        cnt     <= CW'(hi_sh);
        lo_act  <= lo_sh;
      end
    end
  end

  assert_en_marks_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    qclk_en |-> (qclk && !$past(qclk)));

  assert_rise_has_en_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(qclk) |-> qclk_en);

  assert_high_ends_at_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (qclk && zero) |=> !qclk);

  assert_high_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (qclk && !zero) |=> qclk);

  assert_low_bounded_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !qclk |-> (cnt <= CW'(lo_act)));

  assert_refused_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !idle) |=> ($stable(hi_sh) && $stable(lo_sh) && wr_err));

  assert_err_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err |=> wr_err);

  assert_write_loads_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && idle) |=> (hi_sh == $past(wr_hi) && lo_sh == $past(wr_lo)));

endmodule

// File: tb/sim_clk_prescaler.sv
`timescale 1ns/1ps
module sim_clk_prescaler;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [4:0] wr_hi = '0;
  logic [2:0] wr_lo = '0;
  logic       idle = 1'b1;
  logic       qclk, qclk_en, wr_err;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 0;

  always #4 clk = ~clk;

  clk_prescaler u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_hi(wr_hi),
                    .wr_lo(wr_lo), .idle(idle), .qclk(qclk), .qclk_en(qclk_en),
                    .wr_err(wr_err));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int h, input int l, input bit idl);
    @(negedge clk);
    wr_hi = 5'(h); wr_lo = 3'(l); idle = idl; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; idle = 1'b1;
  endtask

  task automatic wait_en();
    do @(negedge clk); while (!qclk_en && !done);
  endtask

  // called just after a negedge where qclk_en was seen
  task automatic measure(output int hc, output int lc);
    bit prev = 1'b1;
    hc = 1; lc = 0;
    chk(qclk == 1'b1, "R4 qclk high with enable", int'(qclk), 1);
    forever begin
      @(negedge clk);
      if (done) break;
      if (qclk_en) begin
        chk(prev == 1'b0 && qclk == 1'b1, "R4 enable only on rise", int'(prev), 0);
        break;
      end
      if (qclk) begin
        hc++;
        if (!prev) chk(0, "R4 rise without enable", 0, 1);
      end else lc++;
      prev = qclk;
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000 && !done) begin
        done = 1;
        chk(0, "watchdog", cycles, 150000);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    int hc, lc;
    repeat (3) @(negedge clk);
    chk(qclk == 0 && qclk_en == 0, "R1 reset outputs", int'({qclk, qclk_en}), 0);
    chk(wr_err == 0, "R1 reset err", int'(wr_err), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(qclk == 1 && qclk_en == 1, "R1 first rise", int'({qclk, qclk_en}), 3);
    measure(hc, lc);
    chk(hc == 1 && lc == 1, "R1 reset divide-by-2", hc * 10 + lc, 11);

    for (int h = 0; h < 32; h++) begin
      for (int l = 0; l < 8; l++) begin
        wr(h, l, 1'b1);
        wait_en();
        wait_en();
        measure(hc, lc);
        chk(hc == h + 1, "R2 high length", hc, h + 1);
        chk(lc == l + 1, "R3 low length", lc, l + 1);
      end
    end

    // R6 collision: write in last low cycle before a rise (config 3,2)
    wr(3, 2, 1'b1);
    wait_en(); wait_en();
    repeat (6) @(negedge clk);
    chk(qclk == 0, "R6 in last low cycle", int'(qclk), 0);
    wr_hi = 5'd0; wr_lo = 3'd0; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    chk(qclk_en == 1, "R6 rise on write edge", int'(qclk_en), 1);
    measure(hc, lc);
    chk(hc == 4 && lc == 3, "R6 old values kept", hc * 10 + lc, 43);
    measure(hc, lc);
    chk(hc == 1 && lc == 1, "R6 new values next period", hc * 10 + lc, 11);

    // R5 refused write
    wr(5, 4, 1'b1);
    wait_en(); wait_en();
    chk(wr_err == 0, "R5 no err after good writes", int'(wr_err), 0);
    wr(20, 7, 1'b0);
    chk(wr_err == 1, "R5 err set", int'(wr_err), 1);
    wait_en(); wait_en();
    measure(hc, lc);
    chk(hc == 6 && lc == 5, "R5 fields unchanged", hc * 10 + lc, 65);
    wr(1, 1, 1'b1);
    chk(wr_err == 1, "R5 err sticky", int'(wr_err), 1);
    wait_en(); wait_en();
    measure(hc, lc);
    chk(hc == 2 && lc == 2, "R6 write after error accepted", hc * 10 + lc, 22);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule